// File: doc/BRIEF.md
# Feedback Divider Step Adjuster

This block holds the feedback divide ratio of a fractional synthesizer loop as an integer part plus a fraction, numerator over denominator. It feeds that ratio straight to a downstream fractional divider. Software-style writes fill a staged bank holding the numerator, the denominator, the integer part and a step word. A soft-reset strobe copies the staged ratio into the active ratio in one step.

Once a ratio is active, the output frequency can be trimmed with two single-cycle strobes. The raise strobe adds the step word to the active numerator and the lower strobe subtracts it. Whenever the numerator leaves the range zero to denominator minus one, it is folded back by one denominator and the integer part moves by one. This lets the ratio move smoothly across whole-number boundaries.

Some requests would take the ratio out of its legal window, or use a step word the block cannot accept. Such requests are dropped and a sticky limit flag is raised.

Top module: `fb_step_adjust`

## Requirements
- R1: After synchronous reset the active ratio is integer part 1, numerator 0, denominator 1. The limit flag is 0, the staged bank holds the same ratio, and the staged step word is 0.
- R2: A write with `wr_en` high updates only the staged field chosen by `wr_sel`, and the active ratio outputs do not change. The select codes are 0 for the numerator (all 56 data bits), 1 for the denominator (data bits 31:0), 2 for the integer part (data bits 24:0) and 3 for the step word (all 56 data bits).
- R3: A `soft_reset` pulse places the staged numerator, denominator and integer part on the active outputs one clock later and clears the limit flag. It takes priority over both step strobes in the same cycle.
- R4: A raise strobe alone adds the step to the numerator. If the sum is at least the denominator, the denominator is subtracted and the integer part grows by one.
- R5: A lower strobe alone subtracts the step from the numerator. If the step exceeds the numerator, the denominator is added back and the integer part shrinks by one.
- R6: When both strobes are high in the same cycle, the active ratio and the limit flag are left unchanged.
- R7: A step result is applied only if the integer part stays between 1 and 2^24, the numerator is 0 whenever the integer part equals 2^24, and the integer part is at least 10 whenever the numerator is non-zero. Otherwise the active ratio is unchanged and the limit flag is set.
- R8: A step request is ignored, and the limit flag set, if the step word exceeds 2^24 or is not smaller than the active denominator.
- R9: Once set, the limit flag stays high until a soft reset or a reset.
- R10: The active outputs are registered. A strobe affects them only after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the staged bank |
| wr_sel | input | 2 | Staged field select |
| wr_data | input | 56 | Write data |
| soft_reset | input | 1 | Copy staged ratio into active ratio |
| step_inc | input | 1 | Raise the ratio by one step |
| step_dec | input | 1 | Lower the ratio by one step |
| ratio_int | output | 25 | Active integer part |
| ratio_num | output | 56 | Active numerator |
| ratio_den | output | 32 | Active denominator |
| limit_hit | output | 1 | Sticky flag for a refused step |

## Verification
The hardest cases to reach are steps that land exactly on a legal edge: the upper bound hit with a zero fraction, or the integer part falling below ten while a fraction remains. A random ratio almost never sits one step from those points. The bench therefore stages ratios placed right next to each edge, commits them with a soft reset, and then strobes across the edge. Random rounds mix small and full-width denominators, integer parts drawn partly from the edge values, and occasional oversized steps. A bench model tracks the expected result of every strobe.

// File: rtl/fb_step_pkg.sv
package fb_step_pkg;

    localparam int NUM_W        = 56;
    localparam int DEN_W        = 32;
    localparam int INT_W        = 25;
    localparam int STEP_W       = 56;
    localparam int DATA_W       = NUM_W;
    localparam int INT_MIN      = 1;
    localparam int INT_MAX      = 1 << (INT_W - 1);
    localparam int FRAC_MIN_INT = 10;
    localparam int STEP_MAX     = 1 << 24;
    localparam int XW           = NUM_W + 1;
    localparam int IW           = INT_W + 1;

    typedef logic [NUM_W-1:0]  num_t;
    typedef logic [DEN_W-1:0]  den_t;
    typedef logic [INT_W-1:0]  whole_t;
    typedef logic [STEP_W-1:0] step_t;

    typedef struct packed {
        whole_t whole;
        num_t   num;
        den_t   den;
    } ratio_t;

    typedef enum logic [1:0] {
        SEL_NUM  = 2'd0,
        SEL_DEN  = 2'd1,
        SEL_INT  = 2'd2,
        SEL_STEP = 2'd3
    } wr_sel_e;

    localparam ratio_t RATIO_RST = '{whole: whole_t'(1), num: '0, den: den_t'(1)};

    // Legal window for a candidate ratio; integer part carried one bit wider.
    function automatic logic ratio_legal(input logic [IW-1:0] iw, input num_t n);
        logic nz;
        nz = (n != '0);
        return (iw >= IW'(INT_MIN)) && (iw <= IW'(INT_MAX)) &&
               !((iw == IW'(INT_MAX)) && nz) &&
               !(nz && (iw < IW'(FRAC_MIN_INT)));
    endfunction

endpackage

// File: rtl/fb_step_regs.sv
module fb_step_regs
    import fb_step_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output ratio_t            staged,
    output step_t             step_word
);
    wr_sel_e sel;
    assign sel = wr_sel_e'(wr_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            staged    <= RATIO_RST;
            step_word <= '0;
        end else if (wr_en) begin
            unique case (sel)
                SEL_NUM:  staged.num   <= num_t'(wr_data);
                SEL_DEN:  staged.den   <= wr_data[DEN_W-1:0];
                SEL_INT:  staged.whole <= wr_data[INT_W-1:0];
                SEL_STEP: step_word    <= step_t'(wr_data);
            endcase
        end
    end
endmodule

// File: rtl/fb_step_calc.sv
module fb_step_calc
    import fb_step_pkg::*;
(
    input  ratio_t cur,
    input  step_t  step_word,
    input  logic   inc,
    input  logic   dec,
    output ratio_t nxt,
    output logic   accept,
    output logic   reject
);
    logic            go;
    logic            step_bad;
    logic [XW-1:0]   den_x;
    logic [XW-1:0]   num_x;
    logic [XW-1:0]   step_x;
    logic [XW-1:0]   sum_up;
    logic [XW-1:0]   cand_num;
    logic [IW-1:0]   cand_int;

    assign go     = inc ^ dec;
    assign den_x  = XW'(cur.den);
    assign num_x  = XW'(cur.num);
    assign step_x = XW'(step_word);
    assign sum_up = num_x + step_x;

    assign step_bad = (step_x > XW'(STEP_MAX)) || (step_x >= den_x);

    always_comb begin
        cand_int = {1'b0, cur.whole};
        if (inc) begin
            if (sum_up >= den_x) begin
                cand_num = sum_up - den_x;
                cand_int = cand_int + IW'(1);
            end else begin
                cand_num = sum_up;
            end
        end else begin
            if (num_x >= step_x) begin
                cand_num = num_x - step_x;
            end else begin
                cand_num = num_x + den_x - step_x;
                cand_int = cand_int - IW'(1);
            end
        end
    end

    assign reject = go && (step_bad || !ratio_legal(cand_int, cand_num[NUM_W-1:0]) ||
                           cand_num[NUM_W]);
    assign accept = go && !reject;

    always_comb begin
        nxt.whole = cand_int[INT_W-1:0];
        nxt.num   = cand_num[NUM_W-1:0];
        nxt.den   = cur.den;
    end
endmodule

// File: rtl/fb_step_adjust.sv
module fb_step_adjust
    import fb_step_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              soft_reset,
    input  logic              step_inc,
    input  logic              step_dec,
    output logic [INT_W-1:0]  ratio_int,
    output logic [NUM_W-1:0]  ratio_num,
    output logic [DEN_W-1:0]  ratio_den,
    output logic              limit_hit
);
    ratio_t staged;
    step_t  step_word;
    ratio_t active;
    ratio_t nxt;
    logic   accept;
    logic   reject;
    logic   flag_q;

    fb_step_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .staged    (staged),
        .step_word (step_word)
    );

    fb_step_calc u_calc (
        .cur       (active),
        .step_word (step_word),
        .inc       (step_inc),
        .dec       (step_dec),
        .nxt       (nxt),
        .accept    (accept),
        .reject    (reject)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= RATIO_RST;
            flag_q <= 1'b0;
        end else if (soft_reset) begin
            active <= staged;
            flag_q <= 1'b0;
        end else begin
            if (accept) active <= nxt;
            if (reject) flag_q <= 1'b1;
        end
    end

    assign ratio_int = active.whole;
    assign ratio_num = active.num;
    assign ratio_den = active.den;
    assign limit_hit = flag_q;

    p_soft_copy_r3: assert property (@(posedge clk) disable iff (rst)
        soft_reset |=> (active == $past(staged)) && !flag_q)
        else $error("soft reset copy failed");

    p_both_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (step_inc && step_dec && !soft_reset) |=> $stable(active) && $stable(flag_q))
        else $error("both strobes changed state");

    p_in_range_r7: assert property (@(posedge clk) disable iff (rst)
        (accept && !soft_reset) |=> (active.whole >= whole_t'(INT_MIN)) &&
                                    (active.whole <= whole_t'(INT_MAX)))
        else $error("accepted step left range");

    p_refuse_r8: assert property (@(posedge clk) disable iff (rst)
        (reject && !soft_reset) |=> flag_q && $stable(active))
        else $error("refused step altered ratio");

    p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !soft_reset) |=> flag_q)
        else $error("limit flag dropped");
endmodule

// File: tb/fb_step_adjust_bench.sv
`timescale 1ns/1ps
module fb_step_adjust_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [1:0]  wr_sel;
    logic [55:0] wr_data;
    logic        soft_reset;
    logic        step_inc;
    logic        step_dec;
    logic [24:0] ratio_int;
    logic [55:0] ratio_num;
    logic [31:0] ratio_den;
    logic        limit_hit;

    int tests = 0;
    int fails = 0;

    // model state
    logic [24:0] mi, si;
    logic [55:0] mn, sn, sst;
    logic [31:0] md, sd;
    logic        mf;

    always #2.5 clk = ~clk;

    fb_step_adjust u_fb_step_adjust (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .soft_reset(soft_reset), .step_inc(step_inc), .step_dec(step_dec),
        .ratio_int(ratio_int), .ratio_num(ratio_num), .ratio_den(ratio_den),
        .limit_hit(limit_hit)
    );

    task automatic check(input string tag);
        tests++;
        if (ratio_int !== mi || ratio_num !== mn || ratio_den !== md || limit_hit !== mf) begin
            fails++;
            $display("FAIL %s: got int=%0d num=%0d den=%0d flag=%0b, expected int=%0d num=%0d den=%0d flag=%0b",
                     tag, ratio_int, ratio_num, ratio_den, limit_hit, mi, mn, md, mf);
        end
    endtask

    task automatic model(input logic we, input logic [1:0] sel, input logic [55:0] d,
                         input logic sr, input logic inc, input logic dec);
        logic [63:0] w;
        longint      ti;
        logic        bad, ok;
        if (sr) begin
            mi = si; mn = sn; md = sd; mf = 1'b0;
        end else if (inc ^ dec) begin
            bad = ({8'b0, sst} > 64'h100_0000) || ({8'b0, sst} >= {32'b0, md});
            w  = {8'b0, mn};
            ti = longint'(mi);
            if (inc) begin
                w = w + {8'b0, sst};
                if (w >= {32'b0, md}) begin w = w - {32'b0, md}; ti = ti + 1; end
            end else begin
                if (mn >= sst) w = w - {8'b0, sst};
                else begin w = w + {32'b0, md} - {8'b0, sst}; ti = ti - 1; end
            end
            ok = !bad && ti >= 1 && ti <= 64'sd16777216 &&
                 !(ti == 64'sd16777216 && w != 0) && !(w != 0 && ti < 10);
            if (ok) begin mi = ti[24:0]; mn = w[55:0]; end
            else mf = 1'b1;
        end
        if (we) begin
            case (sel)
                2'd0: sn = d;
                2'd1: sd = d[31:0];
                2'd2: si = d[24:0];
                default: sst = d;
            endcase
        end
    endtask

    task automatic apply(input logic we, input logic [1:0] sel, input logic [55:0] d,
                         input logic sr, input logic inc, input logic dec, input string tag);
        wr_en = we; wr_sel = sel; wr_data = d;
        soft_reset = sr; step_inc = inc; step_dec = dec;
        model(we, sel, d, sr, inc, dec);
        @(posedge clk); #1;
        wr_en = 0; soft_reset = 0; step_inc = 0; step_dec = 0;
        check(tag);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [55:0] d, input string tag);
        apply(1'b1, sel, d, 1'b0, 1'b0, 1'b0, tag);
    endtask

    task automatic load(input logic [24:0] i, input logic [55:0] n, input logic [31:0] dn,
                        input logic [55:0] st);
        wr(2'd1, {24'b0, dn}, "R2 den write");
        wr(2'd0, n, "R2 num write");
        wr(2'd2, {31'b0, i}, "R2 int write");
        wr(2'd3, st, "R2 step write");
        apply(0, 0, 0, 1'b1, 0, 0, "R3 soft reset load");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] dn;
        logic [55:0] n, st;
        logic [24:0] iv;
        int          pick;
        rst = 1; wr_en = 0; wr_sel = 0; wr_data = 0; soft_reset = 0; step_inc = 0; step_dec = 0;
        mi = 25'd1; mn = 0; md = 32'd1; mf = 0; si = 25'd1; sn = 0; sd = 32'd1; sst = 0;
        repeat (2) @(posedge clk);
        #1 rst = 0;
        check("R1 reset state");

        // staged writes leave active alone
        wr(2'd1, 56'd1000, "R2 den staged only");
        wr(2'd0, 56'd900, "R2 num staged only");
        wr(2'd2, 56'd20, "R2 int staged only");
        wr(2'd3, 56'd300, "R2 step staged only");
        apply(0, 0, 0, 1'b1, 0, 0, "R3 soft reset copy");

        // R10: strobe held without a clock edge does not move outputs
        step_inc = 1; #1;
        check("R10 no change before edge");
        step_inc = 0;

        apply(0, 0, 0, 0, 1, 0, "R4 raise with carry");
        apply(0, 0, 0, 0, 0, 1, "R5 lower with borrow");
        apply(0, 0, 0, 0, 0, 1, "R5 lower no borrow");
        apply(0, 0, 0, 0, 1, 0, "R4 raise no carry");
        apply(0, 0, 0, 0, 1, 1, "R6 both strobes hold");
        wr(2'd3, 56'd1000, "R8 step equal den staged");
        apply(0, 0, 0, 0, 1, 0, "R8 step not below den refused");
        wr(2'd3, 56'd300, "R2 step restore");
        apply(0, 0, 0, 0, 0, 1, "R9 flag stays after good step");
        apply(0, 0, 0, 0, 1, 1, "R6 both strobes keep flag");
        apply(0, 0, 0, 1, 1, 0, "R3 soft reset over strobe");

        // upper edge
        load(25'd16777215, 56'd999, 32'd1000, 56'd1);
        apply(0, 0, 0, 0, 1, 0, "R7 reach top with zero fraction");
        apply(0, 0, 0, 0, 1, 0, "R7 past top refused");
        // fractional minimum
        load(25'd10, 56'd100, 32'd1000, 56'd300);
        apply(0, 0, 0, 0, 0, 1, "R7 fraction below ten refused");
        load(25'd10, 56'd300, 32'd1000, 56'd300);
        apply(0, 0, 0, 0, 0, 1, "R7 land on ten exactly");
        // lower bound on integer ratios
        load(25'd1, 56'd0, 32'd1000, 56'd300);
        apply(0, 0, 0, 0, 0, 1, "R7 below one refused");
        // step word size limit
        load(25'd100, 56'd5, 32'hFFFF_FFFF, 56'h100_0001);
        apply(0, 0, 0, 0, 1, 0, "R8 step over limit refused");
        wr(2'd3, 56'h100_0000, "R2 step at limit");
        apply(0, 0, 0, 0, 1, 0, "R8 step at limit accepted");

        // random rounds
        void'($urandom(32'd5397));
        for (int r = 0; r < 40; r++) begin
            dn = ($urandom % 2) ? (32'd2 + $urandom % 2000) : ($urandom | 32'd1);
            n  = 56'($urandom % dn);
            pick = $urandom % 4;
            iv = (pick == 0) ? 25'd10 : (pick == 1) ? 25'd16777215 :
                 (pick == 2) ? 25'd11 : 25'(10 + $urandom % 16777206);
            st = ($urandom % 8 == 0) ? 56'($urandom) + 56'h100_0000 :
                 56'(($urandom % dn) & 32'h01FF_FFFF);
            load(iv, n, dn, st);
            for (int k = 0; k < 15; k++) begin
                int c;
                c = $urandom % 4;
                apply(0, 0, 0, 0, c[0], c[1], "R4 R5 R7 R8 random strobe");
            end
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule